// File: doc/BRIEF.md
# Linear-Time Ring Polynomial Multiplier

This block multiplies a polynomial a(x) with small signed coefficients by a polynomial b(x) with coefficients modulo q, and returns the product reduced both by a ring polynomial of degree N and by q. The a(x) operand sits in an N-stage shift register whose feedback computes x·a(x) mod p(x) in a single cycle. N multiply-accumulate cells then add b_j times each stage into a wide signed accumulator. A product therefore costs N cycles to load a(x), N cycles of b(x) beats and N cycles of readout.

At run time the caller picks the ring polynomial from three choices: x^N − 1 (cyclic), x^N + 1 (negacyclic) or x^N − x − 1 (trinomial). It also picks one of two parameter moduli. The cells hold no multipliers. A shared table forms every small multiple of the current b_j once, and each cell picks one entry with its stage value as the index. No cell reduces modulo q. The accumulators are wide enough to hold the exact integer sum, and one reducer on the readout path maps each coefficient into 0..q−1 using precomputed reciprocal constants.

Top module: `ring_lfsr_mul`

## Requirements
- R1: While the block is idle, each cycle with `a_load` high shifts `a_coef` (signed, within ±AMAX) into the lowest stage. The first of N loaded values becomes the coefficient of x^(N−1), and the last becomes the constant term.
- R2: With `ring_sel` = 0 (or 3) at start, the result equals a(x)·b(x) mod (x^N − 1, q).
- R3: With `ring_sel` = 1 at start, the result equals a(x)·b(x) mod (x^N + 1, q).
- R4: With `ring_sel` = 2 at start, the result equals a(x)·b(x) mod (x^N − x − 1, q).
- R5: `start` in the idle state clears every accumulator, so one product never leaks into the next.
- R6: `mod_sel` at start selects q = QA (0) or q = QB (1). Every output coefficient lies in 0..q−1.
- R7: After the N-th accepted b beat, exactly N results appear on N consecutive cycles with `r_valid` high. The constant term comes first and the x^(N−1) term last.
- R8: Cycles with `b_valid` low neither shift a(x) nor accumulate, so gaps in the b stream leave the result unchanged.
- R9: `busy` rises the cycle after `start` and falls with the last result. While busy, `start`, `a_load`, `ring_sel` and `mod_sel` have no effect on the result.
- R10: After reset, `busy` and `r_valid` are low.
- R11: Operands at the extremes (every a coefficient at +AMAX or −AMAX, every b coefficient at its largest magnitude) produce correct results without accumulator overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_sel | input | 2 | Ring choice, captured at start: 0 cyclic, 1 negacyclic, 2 trinomial |
| mod_sel | input | 1 | Modulus choice, captured at start: 0 selects QA, 1 selects QB |
| a_load | input | 1 | Shift one a(x) coefficient into the register |
| a_coef | input | AW | Signed a(x) coefficient, highest degree first |
| start | input | 1 | Clear accumulators and begin a product |
| b_valid | input | 1 | A b(x) coefficient is present this cycle |
| b_coef | input | BW | Signed balanced b(x) coefficient, constant term first |
| busy | output | 1 | A product is being computed or read out |
| r_valid | output | 1 | `r_coef` carries a result coefficient |
| r_coef | output | QW | Result coefficient in 0..q−1 |

## Verification
The bench sweeps a single signed monomial through every position of a(x) in all three rings. A wrong load order or a feedback tap in the wrong stage then shows up as a coefficient in the wrong place or with the wrong sign. Random operand runs under both moduli compare every result coefficient with an arithmetic schoolbook model. Extreme-value runs would expose an accumulator that is too narrow, or a reducer that mishandles negative sums. Runs with gaps in the b stream and with stray start, load and select pulses during a product would catch a register that shifts on idle beats or a control path that reacts while busy.

// File: rtl/rlm_pkg.sv
package rlm_pkg;

    typedef enum logic [1:0] {
        RING_CYC = 2'd0,
        RING_NEG = 2'd1,
        RING_TRI = 2'd2
    } ring_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_OUT  = 2'd2
    } phase_e;

endpackage

// File: rtl/rlm_areg.sv
// Shift register for the small operand. Each shift multiplies it by x and
// folds the top coefficient back through the taps of the selected ring.
module rlm_areg
    import rlm_pkg::*;
#(
    parameter int N  = 8,
    parameter int AW = 3,
    parameter int RW = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_en,
    input  logic [AW-1:0]          load_coef,
    input  logic                   shift_en,
    input  ring_e                  ring,
    output logic [N-1:0][RW-1:0]   a_q
);

    logic [N-1:0][RW-1:0] a_d;
    logic [RW-1:0]        top_coef;

    assign top_coef = a_q[N-1];

    always_comb begin
        a_d = a_q;
        if (load_en) begin
            a_d[0] = RW'($signed(load_coef));
            for (int i = 1; i < N; i++) begin
                a_d[i] = a_q[i-1];
            end
        end else if (shift_en) begin
            for (int i = 1; i < N; i++) begin
                a_d[i] = a_q[i-1];
            end
            case (ring)
                RING_NEG: a_d[0] = RW'(0) - top_coef;
                RING_TRI: begin
                    a_d[0] = top_coef;
                    a_d[1] = a_q[0] + top_coef;
                end
                default:  a_d[0] = top_coef;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

endmodule

// File: rtl/rlm_multiples.sv
// Shared table of the small multiples of the current b coefficient.
module rlm_multiples #(
    parameter int BW   = 13,
    parameter int AMAX = 2,
    parameter int MW   = 16,
    parameter int NM   = 4 * AMAX + 1
) (
    input  logic signed [BW-1:0] b,
    output logic signed [MW-1:0] mult [NM]
);

    for (genvar k = 0; k < NM; k++) begin : g_mult
        localparam int FACTOR = k - 2 * AMAX;
        assign mult[k] = MW'(FACTOR) * MW'(b);
    end

endmodule

// File: rtl/rlm_reduce.sv
// Readout reducer: maps a signed accumulator value into 0..q-1 with a
// reciprocal estimate, two corrections and a fixed offset removal.
module rlm_reduce #(
    parameter int CW = 20,
    parameter int QW = 13,
    parameter int QA = 3329,
    parameter int QB = 4096
) (
    input  logic [CW-1:0] x,
    input  logic          qsel,
    output logic [QW-1:0] r
);

    localparam int K   = 2 * CW;
    localparam int PW  = CW + K;
    localparam int TW  = CW + QW + 1;
    localparam int RRW = QW + 2;
    localparam longint unsigned RECIP_A = (64'd1 << K) / 64'(QA);
    localparam longint unsigned RECIP_B = (64'd1 << K) / 64'(QB);
    localparam longint unsigned BIAS_A  = (64'd1 << (CW - 1)) % 64'(QA);
    localparam longint unsigned BIAS_B  = (64'd1 << (CW - 1)) % 64'(QB);

    logic [CW-1:0]  u;
    logic [63:0]    recip;
    logic [RRW-1:0] q_cur;
    logic [RRW-1:0] bias;
    logic [PW-1:0]  prod;
    logic [CW-1:0]  quot;
    logic [TW-1:0]  tq;
    logic [TW-1:0]  diff;
    logic [RRW-1:0] r0, r1, r2, rf;

    always_comb begin
        // biasing by 2^(CW-1) turns the signed value into an unsigned one
        u     = {~x[CW-1], x[CW-2:0]};
        recip = qsel ? RECIP_B : RECIP_A;
        q_cur = qsel ? RRW'(QB) : RRW'(QA);
        bias  = qsel ? RRW'(BIAS_B) : RRW'(BIAS_A);
        prod  = PW'(u) * PW'(recip);
        quot  = prod[PW-1:K];
        tq    = TW'(quot) * TW'(q_cur);
        diff  = TW'(u) - tq;
        r0    = diff[RRW-1:0];
        r1    = (r0 >= q_cur) ? r0 - q_cur : r0;
        r2    = (r1 >= q_cur) ? r1 - q_cur : r1;
        rf    = (r2 >= bias) ? r2 - bias : r2 + q_cur - bias;
        r     = rf[QW-1:0];
    end

endmodule

// File: rtl/ring_lfsr_mul.sv
module ring_lfsr_mul
    import rlm_pkg::*;
#(
    parameter int N    = 8,
    parameter int AW   = 3,
    parameter int AMAX = 2,
    parameter int BW   = 13,
    parameter int QW   = 13,
    parameter int QA   = 3329,
    parameter int QB   = 4096
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           ring_sel,
    input  logic                 mod_sel,
    input  logic                 a_load,
    input  logic [AW-1:0]        a_coef,
    input  logic                 start,
    input  logic                 b_valid,
    input  logic signed [BW-1:0] b_coef,
    output logic                 busy,
    output logic                 r_valid,
    output logic [QW-1:0]        r_coef
);

    // stage values reach twice AMAX in the trinomial ring
    localparam int RW   = AW + 1;
    localparam int NM   = 4 * AMAX + 1;
    localparam int MW   = BW + $clog2(2 * AMAX + 1);
    localparam int CW   = MW + $clog2(N) + 1;
    localparam int CNTW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CNTW-1:0] CNT_LAST = CNTW'(N - 1);

    typedef struct packed {
        phase_e                phase;
        logic [CNTW-1:0]       cnt;
        ring_e                 ring;
        logic                  qsel;
        logic [N-1:0][CW-1:0]  c;
        logic                  rv;
        logic [QW-1:0]         rc;
    } state_t;

    state_t st_d, st_q;

    logic                 load_en;
    logic                 shift_en;
    logic [N-1:0][RW-1:0] a_q;
    logic signed [MW-1:0] mult [NM];
    logic signed [CW-1:0] c_sum [N];
    logic [QW-1:0]        red_out;
    logic [QW-1:0]        q_active;

    rlm_areg #(.N(N), .AW(AW), .RW(RW)) u_areg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_coef (a_coef),
        .shift_en  (shift_en),
        .ring      (st_q.ring),
        .a_q       (a_q)
    );

    rlm_multiples #(.BW(BW), .AMAX(AMAX), .MW(MW), .NM(NM)) u_mult (
        .b    (b_coef),
        .mult (mult)
    );

    rlm_reduce #(.CW(CW), .QW(QW), .QA(QA), .QB(QB)) u_reduce (
        .x    (st_q.c[0]),
        .qsel (st_q.qsel),
        .r    (red_out)
    );

    // one accumulate cell per stage: select a multiple, add it
    for (genvar i = 0; i < N; i++) begin : g_cell
        logic [RW-1:0] sel;
        assign sel      = a_q[i] + RW'(2 * AMAX);
        assign c_sum[i] = $signed(st_q.c[i]) + CW'(mult[sel]);
    end

    always_comb begin
        st_d     = st_q;
        st_d.rv  = 1'b0;
        load_en  = 1'b0;
        shift_en = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_RUN;
                    st_d.cnt   = '0;
                    st_d.ring  = ring_e'(ring_sel);
                    st_d.qsel  = mod_sel;
                    st_d.c     = '0;
                end else begin
                    load_en = a_load;
                end
            end
            PH_RUN: begin
                if (b_valid) begin
                    shift_en = 1'b1;
                    for (int i = 0; i < N; i++) begin
                        st_d.c[i] = c_sum[i];
                    end
                    st_d.cnt = st_q.cnt + 1'b1;
                    if (st_q.cnt == CNT_LAST) begin
                        st_d.phase = PH_OUT;
                        st_d.cnt   = '0;
                    end
                end
            end
            PH_OUT: begin
                st_d.rv = 1'b1;
                st_d.rc = red_out;
                for (int i = 0; i < N - 1; i++) begin
                    st_d.c[i] = st_q.c[i+1];
                end
                st_d.c[N-1] = '0;
                st_d.cnt    = st_q.cnt + 1'b1;
                if (st_q.cnt == CNT_LAST) begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, ring: RING_CYC, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = (st_q.phase != PH_IDLE);
    assign r_valid  = st_q.rv;
    assign r_coef   = st_q.rc;
    assign q_active = st_q.qsel ? QW'(QB) : QW'(QA);

endmodule

// File: rtl/rlm_checker.sv
module rlm_checker #(
    parameter int N  = 8,
    parameter int QW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          r_valid,
    input logic [QW-1:0] r_coef,
    input logic [QW-1:0] q_now
);

    localparam int PCW = $clog2(N + 1) + 1;

    logic [PCW-1:0] pulses;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulses <= '0;
        end else if (start && !busy) begin
            pulses <= '0;
        end else if (r_valid) begin
            pulses <= pulses + 1'b1;
        end
    end

    a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!busy && !r_valid));

    a_r6_coef_below_q: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid |-> (r_coef < q_now));

    a_r7_results_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && busy) |=> r_valid);

    a_r7_result_count: assert property (@(posedge clk) disable iff (!rst_n)
        pulses <= PCW'(N));

    a_r9_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r9_valid_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid |-> $past(busy));

endmodule

bind ring_lfsr_mul rlm_checker #(.N(N), .QW(QW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .r_valid (r_valid),
    .r_coef  (r_coef),
    .q_now   (q_active)
);

// File: tb/ring_lfsr_mul_bench.sv
`timescale 1ns/1ps
module ring_lfsr_mul_bench;

    localparam int N    = 8;
    localparam int AW   = 3;
    localparam int AMAX = 2;
    localparam int BW   = 13;
    localparam int QW   = 13;
    localparam int QA   = 3329;
    localparam int QB   = 4096;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [1:0]           ring_sel = '0;
    logic                 mod_sel = 1'b0;
    logic                 a_load = 1'b0;
    logic [AW-1:0]        a_coef = '0;
    logic                 start = 1'b0;
    logic                 b_valid = 1'b0;
    logic signed [BW-1:0] b_coef = '0;
    logic                 busy;
    logic                 r_valid;
    logic [QW-1:0]        r_coef;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    ring_lfsr_mul #(.N(N), .AW(AW), .AMAX(AMAX), .BW(BW), .QW(QW),
                    .QA(QA), .QB(QB)) u_ring_lfsr_mul (
        .clk(clk), .rst_n(rst_n), .ring_sel(ring_sel), .mod_sel(mod_sel),
        .a_load(a_load), .a_coef(a_coef), .start(start), .b_valid(b_valid),
        .b_coef(b_coef), .busy(busy), .r_valid(r_valid), .r_coef(r_coef)
    );

    task automatic check_eq(input longint act, input longint exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // amode: 0 random, 1 monomial at pos, 2 all +AMAX / max b, 3 all -AMAX / min b
    task automatic do_run(input int ring, input int qs, input int amode, input int pos,
                          input bit gaps, input bit disturb, input string tag);
        int     av[N];
        int     bv[N];
        longint dv[2*N-1];
        longint rv[N];
        int     q;
        int     bhi;
        int     blo;
        int     got;
        int     j;
        q   = qs ? QB : QA;
        bhi = qs ? 2047 : 1664;
        blo = qs ? -2048 : -1664;
        for (int k = 0; k < N; k++) begin
            case (amode)
                1:       av[k] = (k == pos) ? ((pos % 2 == 1) ? -AMAX : 1) : 0;
                2:       av[k] = AMAX;
                3:       av[k] = -AMAX;
                default: av[k] = int'($urandom_range(0, 2 * AMAX)) - AMAX;
            endcase
            case (amode)
                2:       bv[k] = bhi;
                3:       bv[k] = blo;
                default: bv[k] = int'($urandom_range(0, bhi - blo)) + blo;
            endcase
        end
        // schoolbook product, then fold high degrees by the ring polynomial
        for (int k = 0; k < 2 * N - 1; k++) dv[k] = 0;
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++)
                dv[i+k] += longint'(av[i]) * longint'(bv[k]);
        for (int k = 2 * N - 2; k >= N; k--) begin
            if (ring == 1) begin
                dv[k-N] -= dv[k];
            end else if (ring == 2) begin
                dv[k-N]   += dv[k];
                dv[k-N+1] += dv[k];
            end else begin
                dv[k-N] += dv[k];
            end
        end
        for (int k = 0; k < N; k++) rv[k] = ((dv[k] % q) + q) % q;

        // load a(x), highest degree first
        for (int k = N - 1; k >= 0; k--) begin
            a_load = 1'b1;
            a_coef = AW'(av[k]);
            @(posedge clk); #1;
        end
        a_load   = 1'b0;
        start    = 1'b1;
        ring_sel = 2'(ring);
        mod_sel  = qs[0];
        @(posedge clk); #1;
        start = 1'b0;
        j = 0;
        while (j < N) begin
            if (gaps && $urandom_range(0, 2) == 0) begin
                b_valid = 1'b0;
                b_coef  = BW'($urandom);
            end else begin
                b_valid = 1'b1;
                b_coef  = BW'(bv[j]);
                j++;
            end
            if (disturb) begin
                a_load   = 1'b1;
                a_coef   = AW'($urandom_range(0, 3));
                start    = 1'b1;
                ring_sel = 2'($urandom);
                mod_sel  = ~qs[0];
            end
            @(posedge clk); #1;
        end
        b_valid = 1'b0;
        a_load  = 1'b0;
        start   = 1'b0;
        got     = 0;
        for (int c = 0; c < 3 * N; c++) begin
            @(negedge clk);
            if (r_valid) begin
                if (got < N) check_eq(longint'(r_coef), rv[got], tag);
                got++;
            end
        end
        check_eq(got, N, "R7 result count");
        check_eq(busy, 0, "R9 busy low after readout");
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq(busy, 0, "R10 busy in reset");
        check_eq(r_valid, 0, "R10 r_valid in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_eq(busy, 0, "R10 busy after reset");
        check_eq(r_valid, 0, "R10 r_valid after reset");
        @(posedge clk); #1;

        // monomial sweep: load order and feedback placement
        for (int p = 0; p < N; p++) begin
            do_run(0, 0, 1, p, 1'b0, 1'b0, "R1 R2 monomial cyclic");
            do_run(1, 0, 1, p, 1'b0, 1'b0, "R1 R3 monomial negacyclic");
            do_run(2, 1, 1, p, 1'b0, 1'b0, "R1 R4 monomial trinomial");
        end
        // random operands per ring and modulus (back-to-back runs: R5)
        for (int qs = 0; qs < 2; qs++) begin
            for (int t = 0; t < 4; t++) begin
                do_run(0, qs, 0, 0, 1'b0, 1'b0, "R2 R5 R6 cyclic");
                do_run(1, qs, 0, 0, 1'b0, 1'b0, "R3 R5 R6 negacyclic");
                do_run(2, qs, 0, 0, 1'b0, 1'b0, "R4 R5 R6 trinomial");
            end
        end
        do_run(3, 0, 0, 0, 1'b0, 1'b0, "R2 code3 cyclic");
        // extremes
        for (int r = 0; r < 3; r++) begin
            do_run(r, 0, 2, 0, 1'b0, 1'b0, "R11 all max");
            do_run(r, 1, 3, 0, 1'b0, 1'b0, "R11 all min");
        end
        // gaps in the b stream and stray control while busy
        for (int r = 0; r < 3; r++) begin
            do_run(r, r % 2, 0, 0, 1'b1, 1'b0, "R8 gaps");
            do_run(r, 1 - r % 2, 0, 0, 1'b0, 1'b1, "R9 disturb");
            do_run(r, 0, 0, 0, 1'b1, 1'b1, "R8 R9 gaps and disturb");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule